// File: doc/BRIEF.md
# I2C Target Interrupt Flag Register

This block keeps the interrupt flag register of an I2C target peripheral. The bus engine sends single-cycle event strobes: error sources, FIFO level crossings, completed byte, matched address and detected stop. These set individual flags. Each flag also has its own hardware clear conditions, driven by register-access strobes and FIFO levels. Software clears a flag by writing one to its bit. A masked, registered interrupt request leaves the block. When software clears the address-match flag, the block sends a single-cycle request to the bus engine to send ACK or NACK.

The stop-received flag has a small three-state machine. STOP_IDLE means no stop is pending. A qualified stop moves it to STOP_WAIT_MATCH. A valid address match then moves it to STOP_WAIT_CMD, and there a command write clears the flag by hardware and returns it to STOP_IDLE. A software clear of the flag also returns it to STOP_IDLE. A new qualified stop in any state moves it to STOP_WAIT_MATCH, and this transition takes priority over the others.

Top module: `i2c_tgt_irq_flags`

## Requirements
- R1: After reset, `flags`, `irq` and `ack_req` are all 0.
- R2: Bits 6 and 5 of `flags` always read 0. A host write with a 0 in an implemented bit leaves that flag unchanged.
- R3: A host write with a 1 in bit 7, 4, 3, 2, 1 or 0 clears that flag. `flags` shows the cleared value in the cycle after the write.
- R4: A pulse on any one of the five `err_evt` lines sets bit 7 (error).
- R5: `rx_at_thresh` sets bit 4 and `rx_empty` clears it. `tx_at_thresh` sets bit 3 and `tx_full` clears it.
- R6: `byte_done` sets bit 2. Bit 2 is cleared by `data_wr`, by `cmd_wr`, or by `data_rd` while `smart_en` is 1. `data_rd` while `smart_en` is 0 leaves bit 2 unchanged.
- R7: `addr_valid` sets bit 1 and `cmd_wr` clears it.
- R8: A host write of 1 to bit 1 while bit 1 is set, with no `addr_valid` in the same cycle, makes `ack_req` high for exactly one cycle. That cycle is the same one in which bit 1 reads 0. In that cycle `ack_nack` equals `ack_action` at the time of the write (0 = ACK, 1 = NACK). No pulse occurs if bit 1 was already clear.
- R9: `stop_seen` sets bit 0 only when `stop_ours` or `group_cmd_en` is 1.
- R10: After a qualified stop, a `cmd_wr` clears bit 0 only if an `addr_valid` came after the stop. A `cmd_wr` before that match leaves bit 0 set.
- R11: When a set event and a clear condition (hardware or software) hit the same flag in the same cycle, the flag ends up set.
- R12: `irq` is registered. In every cycle it equals the OR of (`flags` AND the `irq_en` value sampled at the same edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt | input | ERR_N (5) | Error source strobes: length, extended timeout, low timeout, collision, bus error |
| rx_at_thresh | input | 1 | RX FIFO fill reached its threshold |
| rx_empty | input | 1 | RX FIFO is empty |
| tx_at_thresh | input | 1 | TX FIFO free space reached its threshold |
| tx_full | input | 1 | TX FIFO is full |
| byte_done | input | 1 | Target byte transfer completed successfully |
| addr_valid | input | 1 | Address comparator matched a received address |
| stop_seen | input | 1 | Stop condition detected on the bus |
| stop_ours | input | 1 | The stop ends a transaction this target takes part in |
| group_cmd_en | input | 1 | Group-command mode: any stop qualifies |
| data_wr | input | 1 | DATA register write strobe |
| data_rd | input | 1 | DATA register read strobe |
| smart_en | input | 1 | Smart mode enable |
| cmd_wr | input | 1 | Valid command written to the command field |
| ack_action | input | 1 | Acknowledge selection, 0 = ACK, 1 = NACK |
| host_wr | input | 1 | Host write strobe to the flag register |
| host_wdata | input | 8 | Host write data, one bit per flag position |
| irq_en | input | 8 | Per-bit interrupt enable mask |
| flags | output | 8 | Flag register value |
| irq | output | 1 | Masked, registered interrupt request |
| ack_req | output | 1 | One-cycle request to send ACK/NACK |
| ack_nack | output | 1 | Selected response, valid with `ack_req` |

## Verification
The main collision is a set event for a flag and a software write-one clear of that flag in the same cycle. The bench drives both strobes on the same edge, for example `addr_valid` together with a host write of 0x02. It expects the flag to stay set and `ack_req` to stay low. A second collision is a hardware clear and a set on the same flag, such as `byte_done` with `data_wr`, which is judged the same way. A behavioural model in the bench, updated on every edge, checks all other cycles of the random stimulus.

// File: rtl/i2c_tgt_irq_pkg.sv
package i2c_tgt_irq_pkg;
    localparam int FLAG_W  = 8;
    localparam int ERR_N   = 5;
    // bit positions are fixed: software decodes them
    localparam int B_ERR   = 7;
    localparam int B_RXF   = 4;
    localparam int B_TXE   = 3;
    localparam int B_DRDY  = 2;
    localparam int B_AMAT  = 1;
    localparam int B_STOP  = 0;
    localparam logic [FLAG_W-1:0] IMPL_MASK = 8'b1001_1111;

    typedef enum logic [1:0] {
        STOP_IDLE       = 2'd0,
        STOP_WAIT_MATCH = 2'd1,
        STOP_WAIT_CMD   = 2'd2
    } stop_state_t;
endpackage

// File: rtl/i2c_tgt_flag_cell.sv
module i2c_tgt_flag_cell #(
    parameter bit IMPL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic sw_clr_i,
    output logic flag_d_o,
    output logic flag_q_o
);
    logic q;

    // set has priority over every clear so no event is lost
    always_comb begin
        flag_d_o = IMPL ? (set_i | (q & ~hw_clr_i & ~sw_clr_i)) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= flag_d_o;
    end

    assign flag_q_o = q;
endmodule

// File: rtl/i2c_tgt_stop_fsm.sv
module i2c_tgt_stop_fsm
    import i2c_tgt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_set,
    input  logic stop_sw_clr,
    input  logic addr_valid,
    input  logic cmd_wr,
    output logic stop_hw_clr
);
    stop_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= STOP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx    = state;
        stop_hw_clr = 1'b0;
        unique case (state)
            STOP_IDLE: begin
                if (stop_set) state_nx = STOP_WAIT_MATCH;
            end
            STOP_WAIT_MATCH: begin
                if (stop_set)         state_nx = STOP_WAIT_MATCH;
                else if (stop_sw_clr) state_nx = STOP_IDLE;
                else if (addr_valid)  state_nx = STOP_WAIT_CMD;
            end
            STOP_WAIT_CMD: begin
                stop_hw_clr = cmd_wr;
                if (stop_set)         state_nx = STOP_WAIT_MATCH;
                else if (stop_sw_clr) state_nx = STOP_IDLE;
                else if (cmd_wr)      state_nx = STOP_IDLE;
            end
            default: state_nx = STOP_IDLE;
        endcase
    end
endmodule

// File: rtl/i2c_tgt_irq_flags.sv
module i2c_tgt_irq_flags
    import i2c_tgt_irq_pkg::*;
#(
    parameter int ERR_W = ERR_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_evt,
    input  logic             rx_at_thresh,
    input  logic             rx_empty,
    input  logic             tx_at_thresh,
    input  logic             tx_full,
    input  logic             byte_done,
    input  logic             addr_valid,
    input  logic             stop_seen,
    input  logic             stop_ours,
    input  logic             group_cmd_en,
    input  logic             data_wr,
    input  logic             data_rd,
    input  logic             smart_en,
    input  logic             cmd_wr,
    input  logic             ack_action,
    input  logic             host_wr,
    input  logic [7:0]       host_wdata,
    input  logic [7:0]       irq_en,
    output logic [7:0]       flags,
    output logic             irq,
    output logic             ack_req,
    output logic             ack_nack
);
    logic [FLAG_W-1:0] set_v, hw_clr_v, sw_clr_v, flags_d, flags_q;
    logic              stop_set, stop_hw_clr;
    logic              irq_q, ack_req_q, ack_nack_q;

    assign stop_set = stop_seen & (stop_ours | group_cmd_en);
    assign sw_clr_v = host_wr ? (host_wdata & IMPL_MASK) : '0;

    always_comb begin
        set_v    = '0;
        hw_clr_v = '0;
        set_v[B_ERR]     = |err_evt;
        set_v[B_RXF]     = rx_at_thresh;
        hw_clr_v[B_RXF]  = rx_empty;
        set_v[B_TXE]     = tx_at_thresh;
        hw_clr_v[B_TXE]  = tx_full;
        set_v[B_DRDY]    = byte_done;
        hw_clr_v[B_DRDY] = data_wr | (data_rd & smart_en) | cmd_wr;
        set_v[B_AMAT]    = addr_valid;
        hw_clr_v[B_AMAT] = cmd_wr;
        set_v[B_STOP]    = stop_set;
        hw_clr_v[B_STOP] = stop_hw_clr;
    end

    i2c_tgt_stop_fsm u_stop (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_set    (stop_set),
        .stop_sw_clr (sw_clr_v[B_STOP]),
        .addr_valid  (addr_valid),
        .cmd_wr      (cmd_wr),
        .stop_hw_clr (stop_hw_clr)
    );

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        i2c_tgt_flag_cell #(.IMPL(IMPL_MASK[i])) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_v[i]),
            .hw_clr_i (hw_clr_v[i]),
            .sw_clr_i (sw_clr_v[i]),
            .flag_d_o (flags_d[i]),
            .flag_q_o (flags_q[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q      <= 1'b0;
            ack_req_q  <= 1'b0;
            ack_nack_q <= 1'b0;
        end else begin
            irq_q     <= |(flags_d & irq_en);
            ack_req_q <= sw_clr_v[B_AMAT] & flags_q[B_AMAT] & ~addr_valid;
            if (sw_clr_v[B_AMAT] & flags_q[B_AMAT] & ~addr_valid)
                ack_nack_q <= ack_action;
        end
    end

    assign flags    = flags_q;
    assign irq      = irq_q;
    assign ack_req  = ack_req_q;
    assign ack_nack = ack_nack_q;
endmodule

// File: rtl/i2c_tgt_irq_flags_chk.sv
module i2c_tgt_irq_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] err_evt,
    input logic       byte_done,
    input logic       addr_valid,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic [7:0] irq_en,
    input logic [7:0] flags,
    input logic       irq,
    input logic       ack_req
);
    assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flags[6:5] == 2'b00);

    assert_err_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wdata[7] && err_evt == 5'd0) |=> !flags[7]);

    assert_err_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt != 5'd0) |=> flags[7]);

    assert_amatch_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> flags[1]);

    assert_drdy_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> flags[2]);

    assert_ack_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> ($past(flags[1]) && !flags[1]));

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> !ack_req);

    assert_irq_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == |(flags & $past(irq_en))));
endmodule

bind i2c_tgt_irq_flags i2c_tgt_irq_flags_chk u_chk (.*);

// File: tb/i2c_tgt_irq_flags_test.sv
module i2c_tgt_irq_flags_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] err_evt = '0;
    logic rx_at_thresh = 0, rx_empty = 0, tx_at_thresh = 0, tx_full = 0;
    logic byte_done = 0, addr_valid = 0, stop_seen = 0, stop_ours = 0;
    logic group_cmd_en = 0, data_wr = 0, data_rd = 0, smart_en = 0;
    logic cmd_wr = 0, ack_action = 0, host_wr = 0;
    logic [7:0] host_wdata = '0, irq_en = '0;
    logic [7:0] flags;
    logic irq, ack_req, ack_nack;

    int checks = 0, fails = 0;
    logic [7:0] m_flags = '0;
    logic m_irq = 0, m_ack = 0, m_nack = 0;
    int   m_phase = 0;

    always #4 clk = ~clk;

    i2c_tgt_irq_flags uut (.*);

    // behavioural reference, updated on every rising edge
    always @(posedge clk or negedge rst_n) begin
        logic [7:0] s, h, w, n;
        if (!rst_n) begin
            m_flags = 0; m_irq = 0; m_ack = 0; m_nack = 0; m_phase = 0;
        end else begin
            s = 0; h = 0;
            w = host_wr ? host_wdata : 8'h00;
            s[7] = |err_evt;
            s[4] = rx_at_thresh;  h[4] = rx_empty;
            s[3] = tx_at_thresh;  h[3] = tx_full;
            s[2] = byte_done;     h[2] = data_wr | cmd_wr | (data_rd & smart_en);
            s[1] = addr_valid;    h[1] = cmd_wr;
            s[0] = stop_seen & (stop_ours | group_cmd_en);
            h[0] = (m_phase == 2) && cmd_wr;
            n = (s | (m_flags & ~h & ~w)) & 8'b1001_1111;
            m_ack = w[1] && m_flags[1] && !addr_valid;
            if (m_ack) m_nack = ack_action;
            if (s[0]) m_phase = 1;
            else if (w[0]) m_phase = 0;
            else if (m_phase == 1 && addr_valid) m_phase = 2;
            else if (m_phase == 2 && cmd_wr) m_phase = 0;
            m_flags = n;
            m_irq = |(n & irq_en);
        end
    end

    function automatic string req_of(int b);
        case (b)
            7: return "R4";
            6, 5: return "R2";
            4, 3: return "R5";
            2: return "R6";
            1: return "R7";
            default: return "R9/R10";
        endcase
    endfunction

    always @(negedge clk) if (rst_n) begin
        for (int b = 0; b < 8; b++) begin
            checks++;
            if (flags[b] !== m_flags[b]) begin
                fails++;
                $display("FAIL %s model flags[%0d] actual=%b expected=%b", req_of(b), b, flags[b], m_flags[b]);
            end
        end
        checks++;
        if (irq !== m_irq) begin
            fails++; $display("FAIL R12 model irq actual=%b expected=%b", irq, m_irq);
        end
        checks++;
        if (ack_req !== m_ack || (m_ack && ack_nack !== m_nack)) begin
            fails++;
            $display("FAIL R8 model ack actual=%b/%b expected=%b/%b", ack_req, ack_nack, m_ack, m_nack);
        end
    end

    task automatic tick();
        @(negedge clk);
        err_evt = 0; rx_at_thresh = 0; rx_empty = 0; tx_at_thresh = 0; tx_full = 0;
        byte_done = 0; addr_valid = 0; stop_seen = 0; data_wr = 0; data_rd = 0;
        cmd_wr = 0; host_wr = 0; host_wdata = 0;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w1c(logic [7:0] v);
        host_wr = 1; host_wdata = v; tick();
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flags", flags, 0); chk("R1 irq", irq, 0); chk("R1 ack", ack_req, 0);
        rst_n = 1; tick();
        chk("R1 flags after release", flags, 0);
        for (int i = 0; i < 5; i++) begin
            err_evt = 5'd1 << i; tick();
            chk("R4 error source", flags[7], 1);
            w1c(8'h00); chk("R2 write zero keeps", flags[7], 1);
            w1c(8'h80); chk("R3 w1c error", flags[7], 0);
        end
        w1c(8'hFF); chk("R2 unimplemented", flags[6:5], 0);
        rx_at_thresh = 1; tx_at_thresh = 1; tick();
        chk("R5 rx/tx set", flags[4:3], 2'b11);
        rx_empty = 1; tick(); chk("R5 rx empty clears", flags[4:3], 2'b01);
        tx_full = 1; tick(); chk("R5 tx full clears", flags[4:3], 2'b00);
        byte_done = 1; tick(); chk("R6 drdy set", flags[2], 1);
        data_rd = 1; tick(); chk("R6 read no smart keeps", flags[2], 1);
        smart_en = 1; data_rd = 1; tick(); chk("R6 smart read clears", flags[2], 0);
        smart_en = 0;
        byte_done = 1; tick(); data_wr = 1; tick(); chk("R6 data write clears", flags[2], 0);
        byte_done = 1; tick(); cmd_wr = 1; tick(); chk("R6 cmd clears drdy", flags[2], 0);
        byte_done = 1; data_wr = 1; tick(); chk("R11 drdy set beats hw clear", flags[2], 1);
        w1c(8'h04);
        addr_valid = 1; tick(); chk("R7 amatch set", flags[1], 1);
        cmd_wr = 1; tick(); chk("R7 cmd clears amatch", flags[1], 0);
        addr_valid = 1; tick(); ack_action = 1;
        w1c(8'h02);
        chk("R8 ack pulse", ack_req, 1); chk("R8 nack sel", ack_nack, 1);
        chk("R3 amatch cleared", flags[1], 0);
        tick(); chk("R8 pulse ends", ack_req, 0);
        w1c(8'h02); chk("R8 no pulse when clear", ack_req, 0);
        addr_valid = 1; tick(); ack_action = 0;
        addr_valid = 1; host_wr = 1; host_wdata = 8'h02; tick();
        chk("R11 set beats w1c", flags[1], 1); chk("R11 no ack on collision", ack_req, 0);
        w1c(8'h02); chk("R8 ack sel", {ack_req, ack_nack}, 2'b10);
        stop_seen = 1; tick(); chk("R9 foreign stop ignored", flags[0], 0);
        group_cmd_en = 1; stop_seen = 1; tick(); chk("R9 group stop sets", flags[0], 1);
        group_cmd_en = 0; w1c(8'h01); chk("R3 w1c stop", flags[0], 0);
        stop_ours = 1; stop_seen = 1; tick(); stop_ours = 0;
        chk("R9 own stop sets", flags[0], 1);
        cmd_wr = 1; tick(); chk("R10 cmd before match keeps", flags[0], 1);
        addr_valid = 1; tick();
        cmd_wr = 1; tick(); chk("R10 cmd after match clears", flags[1:0], 2'b00);
        irq_en = 8'h04; byte_done = 1; tick();
        chk("R12 irq with flag", irq, 1);
        irq_en = 8'h01; tick(); chk("R12 irq masked", irq, 0);
        for (int k = 0; k < 3000; k++) begin
            err_evt = ($urandom % 16 == 0) ? 5'($urandom) : 5'd0;
            rx_at_thresh = ($urandom % 6 == 0); rx_empty = ($urandom % 6 == 0);
            tx_at_thresh = ($urandom % 6 == 0); tx_full = ($urandom % 6 == 0);
            byte_done = ($urandom % 5 == 0); addr_valid = ($urandom % 5 == 0);
            stop_seen = ($urandom % 5 == 0); stop_ours = $urandom; group_cmd_en = ($urandom % 4 == 0);
            data_wr = ($urandom % 6 == 0); data_rd = ($urandom % 6 == 0); smart_en = $urandom;
            cmd_wr = ($urandom % 5 == 0); ack_action = $urandom;
            host_wr = ($urandom % 3 == 0); host_wdata = 8'($urandom); irq_en = 8'($urandom);
            tick();
        end
        tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule